// File: doc/BRIEF.md
# Clocked Byte-Wide Static Memory Front End

This block sits behind the pins of a byte-wide static memory and turns its three active-low strobes into clocked cycles. The strobes are chip select, output enable and write enable. It classifies each clock as idle, read or write and keeps a small internal byte array. It produces the data-out value and the drive-enable for the bidirectional data pins. The strobes, the address and the incoming data all pass through the same synchronizer depth, so they stay aligned with each other. Every timing limit is a parameter counted in clock cycles.

A read presents data only once three conditions hold. The address must have been steady for its access time. Chip select must have been active for its own access time. Output enable must have been active for its own access time as well. A write is bracketed by both write strobes being active. The byte is committed when that bracket closes, using the bus value from the final cycle inside it. A power-supervisor input blocks the whole interface. When it is set, all strobes are ignored and the data pins stay undriven.

Top module: `sram_cycle_front`

## Requirements
- R1: After reset, `dout_en` and `proto_err` are 0 and `cyc_state` is 0 (idle).
- R2: A read presents data (`dout_en` rises) exactly SYNC_STAGES+2+T cycles after a pin event. The event is the address settling with T=T_ADDR, chip select falling with T=T_CS, or output enable falling with T=T_OE. The latest of these conditions decides.
- R3: While `dout_en` is 1, `dout` equals the byte most recently committed at the synchronized address.
- R4: A change of address during an enabled read turns the drivers off SYNC_STAGES+1 cycles after the change. They turn back on with the new byte SYNC_STAGES+2+T_ADDR cycles after the change.
- R5: A write bracket opens only when both chip select and write enable are low, whichever falls later. It closes when either of them rises. The byte stored is the `din` value present in the last cycle before the bracket closed.
- R6: Write enable falling during an enabled read turns the drivers off SYNC_STAGES+1 cycles after that edge. They stay on up to that point.
- R7: An address change inside an open write bracket raises `proto_err` for one cycle. Writes with a steady address never raise it.
- R8: After write enable rises, it must stay high for T_REC synchronized cycles. A write-enable low pulse inside that interval opens no bracket and stores nothing. A write after the interval stores normally.
- R9: While `wprot` is 1, writes store nothing, `dout_en` stays 0 and `cyc_state` stays idle.
- R10: `cyc_state` encodes 0 = idle, 1 = read (select and output enable low, write enable high), 2 = write bracket open. It never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data arriving from the data pins |
| wprot | input | 1 | Write protect from the power supervisor, active high |
| dout | output | DATA_W | Data to drive onto the data pins |
| dout_en | output | 1 | Drive enable for the data pins |
| proto_err | output | 1 | One-cycle pulse when the address moves inside a write bracket |
| cyc_state | output | 2 | Current cycle class: 0 idle, 1 read, 2 write |

## Verification
Reads are tried in three arrangements:
- Address, select and output enable all change together. This shows the address access time dominating.
- Output enable falls long after the others. This isolates the output-enable limit.
- The address moves under a live read. This shows the drivers dropping and the access being re-timed.

Writes are tried with chip select falling last, with write enable falling last, and with chip select rising first. Each arrangement has different data on the bus before and after the bracket edge, so a commit on the wrong edge stores a different byte. A short write-enable pulse during recovery, a moving address inside a bracket and a write under protection each have a clean counterpart. That pairing separates rejected cycles from accepted ones.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned width_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sram_fe_sync.sv
module sram_fe_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("sram_fe_sync: W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("sram_fe_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/sram_fe_timer.sv
module sram_fe_timer #(
   parameter int unsigned      NCH = 3,
   parameter int unsigned      CW  = 3,
   parameter logic [NCH*CW-1:0] THR = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] restart,
   output logic           ready
);

   localparam logic [CW-1:0] AGE_SAT = {CW{1'b1}};

   logic [NCH-1:0] ok;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam logic [CW-1:0] LIMIT = THR[ch*CW +: CW];
      logic [CW-1:0] age;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               age <= AGE_SAT;
         else if (restart[ch])     age <= '0;
         else if (age != AGE_SAT)  age <= age + 1'b1;
      end

      assign ok[ch] = !restart[ch] && (age >= LIMIT);
   end

   assign ready = &ok;

endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << AW;

   if (DEPTH > 4096) begin : g_too_deep
      $error("sram_fe_array: array depth exceeds 4096 entries");
   end

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sram_cycle_front.sv
module sram_cycle_front
   import sram_fe_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned T_ADDR      = 4,
   parameter int unsigned T_CS        = 3,
   parameter int unsigned T_OE        = 1,
   parameter int unsigned T_REC       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              wprot,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              proto_err,
   output logic [1:0]        cyc_state
);

   localparam int unsigned MAXD = max3(T_ADDR, T_CS, T_OE);
   localparam int unsigned CW   = width_for(MAXD + 1);
   localparam int unsigned RW   = width_for(T_REC + 1);
   localparam int unsigned BUSW = ADDR_W + DATA_W;
   localparam logic [3*CW-1:0] THR_PACK = {CW'(T_OE), CW'(T_CS), CW'(T_ADDR)};
   localparam logic [RW-1:0]   REC_LOAD = RW'(T_REC);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("sram_cycle_front: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("sram_cycle_front: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("sram_cycle_front: SYNC_STAGES must be at least 1");
   end

   // control strobes converted to active-high, then synchronized
   logic [3:0] ctl_raw, ctl_s;
   assign ctl_raw = {wprot, ~we_n, ~oe_n, ~cs_n};

   sram_fe_sync #(.W(4), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ctl_raw),
      .q    (ctl_s)
   );

   // address and data delayed by the same depth to stay aligned
   logic [BUSW-1:0] bus_raw, bus_s;
   assign bus_raw = {addr, din};

   sram_fe_sync #(.W(BUSW), .STAGES(SYNC_STAGES)) u_bus_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (bus_raw),
      .q    (bus_s)
   );

   logic              cs_s, oe_s, we_s, wp_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   assign cs_s   = ctl_s[0];
   assign oe_s   = ctl_s[1];
   assign we_s   = ctl_s[2];
   assign wp_s   = ctl_s[3];
   assign addr_s = bus_s[BUSW-1:DATA_W];
   assign din_s  = bus_s[DATA_W-1:0];

   // history registers
   logic              cs_prev, oe_prev, we_prev, win_q;
   logic [ADDR_W-1:0] addr_prev;
   logic [DATA_W-1:0] din_prev;
   logic [RW-1:0]     rec_cnt;

   logic cs_act, busy, rec_idle, rd_sel, wr_win, addr_ev, commit, rd_ready, rd_valid;

   assign cs_act   = cs_s & ~wp_s;
   assign busy     = (rec_cnt != '0);
   assign rec_idle = ~busy;
   assign addr_ev  = (addr_s != addr_prev);
   assign rd_sel   = cs_act & oe_s & ~we_s & ~busy;
   assign wr_win   = cs_act & we_s & (win_q | ~busy);
   assign commit   = win_q & ~wr_win & ~wp_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b0;
         oe_prev   <= 1'b0;
         we_prev   <= 1'b0;
         win_q     <= 1'b0;
         addr_prev <= '0;
         din_prev  <= '0;
      end else begin
         cs_prev   <= cs_act;
         oe_prev   <= oe_s;
         we_prev   <= we_s;
         win_q     <= wr_win;
         addr_prev <= addr_s;
         din_prev  <= din_s;
      end
   end

   // write recovery: loaded when write enable releases, counts only while it stays high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rec_cnt <= '0;
      else if (we_prev && !we_s) rec_cnt <= REC_LOAD;
      else if (!we_s && busy)    rec_cnt <= rec_cnt - 1'b1;
   end

   // per-event access timing: address, chip select, output enable
   logic [2:0] restart;
   assign restart[0] = addr_ev;
   assign restart[1] = ~cs_act | ~cs_prev;
   assign restart[2] = ~oe_s | ~oe_prev;

   sram_fe_timer #(.NCH(3), .CW(CW), .THR(THR_PACK)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .ready  (rd_ready)
   );

   assign rd_valid = rd_sel & rd_ready;

   logic [DATA_W-1:0] rd_data;

   sram_fe_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk    (clk),
      .wr_en  (commit),
      .wr_addr(addr_prev),
      .wr_data(din_prev),
      .rd_addr(addr_s),
      .rd_data(rd_data)
   );

   // registered pin-side outputs
   logic [DATA_W-1:0] dout_q;
   logic              dout_en_q, proto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q    <= '0;
         dout_en_q <= 1'b0;
         proto_q   <= 1'b0;
      end else begin
         dout_en_q <= rd_valid;
         if (rd_valid) dout_q <= rd_data;
         proto_q   <= win_q & wr_win & addr_ev;
      end
   end

   cyc_e cyc;
   always_comb begin
      if (wr_win)      cyc = CYC_WRITE;
      else if (rd_sel) cyc = CYC_READ;
      else             cyc = CYC_IDLE;
   end

   assign dout      = dout_q;
   assign dout_en   = dout_en_q;
   assign proto_err = proto_q;
   assign cyc_state = cyc;

endmodule

// File: rtl/sram_cycle_front_chk.sv
module sram_cycle_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_s,
   input logic       we_s,
   input logic       win_q,
   input logic       rec_idle,
   input logic       dout_en,
   input logic       proto_err,
   input logic [1:0] cyc_state
);

   // R9: protection keeps the pins undriven
   p_off_in_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wp_s |=> !dout_en);

   // R9: protection never leaves a write bracket open
   p_no_bracket_in_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wp_s |=> !win_q);

   // R6: write enable takes the drivers off
   p_we_drops_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_s |=> !dout_en);

   // R7: protocol error only follows an open bracket
   p_err_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> $past(win_q));

   // R8: a bracket opens only once recovery has elapsed
   p_open_after_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_q) |-> $past(rec_idle));

   // R10: cycle class encoding stays legal
   always @(posedge clk) begin
      if (rst_n) begin
         p_state_legal_r10: assert (cyc_state != 2'd3);
      end
   end

endmodule

bind sram_cycle_front sram_cycle_front_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wp_s     (wp_s),
   .we_s     (we_s),
   .win_q    (win_q),
   .rec_idle (rec_idle),
   .dout_en  (dout_en),
   .proto_err(proto_err),
   .cyc_state(cyc_state)
);

// File: tb/sram_cycle_front_test.sv
module sram_cycle_front_test;

   localparam int AW = 6;
   localparam int DW = 8;
   localparam int SYNC = 2;
   localparam int TA = 4;
   localparam int TC = 3;
   localparam int TO = 1;
   localparam int TR = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wprot = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en, proto_err;
   logic [1:0]    cyc_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit err_seen = 1'b0;

   always #10 clk = ~clk;

   sram_cycle_front #(
      .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC),
      .T_ADDR(TA), .T_CS(TC), .T_OE(TO), .T_REC(TR)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .wprot(wprot), .dout(dout), .dout_en(dout_en),
      .proto_err(proto_err), .cyc_state(cyc_state)
   );

   always @(negedge clk) if (proto_err) err_seen = 1'b1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); addr = a; din = d; cs_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      idle(SYNC + 1);
      chk("R10 write class", cyc_state, 2);
      idle(2);
      we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      idle(TR + SYNC + 4);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      @(negedge clk); addr = a; cs_n = 1'b0; oe_n = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (dout_en) break;
      end
      chk({req, " read enable"}, dout_en, 1);
      chk({req, " read data"}, dout, exp);
      cs_n = 1'b1; oe_n = 1'b1;
      idle(SYNC + 3);
   endtask

   // counts clock edges from the current negedge until dout_en is seen high
   task automatic wait_rise(output int n);
      n = 99;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (dout_en) begin n = i; break; end
      end
   endtask

   task automatic t_reset;
      chk("R1 dout_en after reset", dout_en, 0);
      chk("R1 proto_err after reset", proto_err, 0);
      chk("R1 idle class after reset", cyc_state, 0);
   endtask

   task automatic t_read_timing;
      int n;
      do_write(7, 8'h3C);
      do_write(9, 8'hA5);
      @(negedge clk); addr = 1; idle(SYNC + 4);
      // R2: address, select and enable together; address time dominates
      addr = 7; cs_n = 1'b0; oe_n = 1'b0;
      idle(SYNC);
      chk("R10 read class", cyc_state, 1);
      wait_rise(n);
      chk("R2 latency all together", n + SYNC, SYNC + 2 + TA);
      chk("R3 data at 7", dout, 8'h3C);
      cs_n = 1'b1; oe_n = 1'b1; idle(SYNC + 3);
      // R2: output enable last
      cs_n = 1'b0; idle(8);
      oe_n = 1'b0;
      wait_rise(n);
      chk("R2 latency enable last", n, SYNC + 2 + TO);
   endtask

   task automatic t_addr_switch;
      int rise;
      rise = 99;
      addr = 9;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (i == SYNC + 1) chk("R4 drivers off after address move", dout_en, 0);
         if (i > SYNC + 1 && dout_en) begin rise = i; break; end
      end
      chk("R4 re-timed latency", rise, SYNC + 2 + TA);
      chk("R4 new data", dout, 8'hA5);
   endtask

   task automatic t_we_hiz;
      din = 8'hA5;
      we_n = 1'b0;
      for (int i = 1; i <= SYNC + 1; i++) begin
         @(negedge clk);
         if (i == SYNC)     chk("R6 still driving", dout_en, 1);
         if (i == SYNC + 1) chk("R6 drivers off", dout_en, 0);
      end
      idle(2);
      we_n = 1'b1; oe_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      idle(TR + SYNC + 4);
      do_read(9, 8'hA5, "R3 after read-write");
   endtask

   task automatic t_close_on_cs;
      @(negedge clk); addr = 12; din = 8'h5A; cs_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      idle(4);
      cs_n = 1'b1; din = 8'hC3;
      idle(2);
      we_n = 1'b1;
      idle(TR + SYNC + 4);
      do_read(12, 8'h5A, "R5 close on select");
   endtask

   task automatic t_open_late;
      @(negedge clk); addr = 13; din = 8'h11; we_n = 1'b0;
      idle(SYNC + 2);
      chk("R5 no bracket without select", cyc_state, 0);
      cs_n = 1'b0; din = 8'h22;
      idle(4);
      din = 8'h77;
      idle(3);
      we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      idle(TR + SYNC + 4);
      do_read(13, 8'h77, "R5 select falls last");
   endtask

   task automatic t_proto;
      err_seen = 1'b0;
      do_write(20, 8'h40);
      chk("R7 clean write no error", err_seen, 0);
      @(negedge clk); addr = 21; din = 8'h41; cs_n = 1'b0; we_n = 1'b0;
      idle(4);
      addr = 22;
      idle(4);
      we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      idle(TR + SYNC + 4);
      chk("R7 moving address flagged", err_seen, 1);
   endtask

   task automatic t_recovery;
      @(negedge clk); addr = 30; din = 8'h11; cs_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      idle(4);
      we_n = 1'b1;
      @(negedge clk); we_n = 1'b0; din = 8'h22;
      idle(TR);
      we_n = 1'b1;
      idle(2);
      cs_n = 1'b1;
      idle(TR + SYNC + 4);
      do_read(30, 8'h11, "R8 early pulse ignored");
      do_write(30, 8'h33);
      do_read(30, 8'h33, "R8 write after recovery");
   endtask

   task automatic t_protect;
      int drove;
      drove = 0;
      @(negedge clk); wprot = 1'b1;
      idle(SYNC + 2);
      addr = 30; din = 8'h99; cs_n = 1'b0;
      @(negedge clk); we_n = 1'b0;
      idle(SYNC + 2);
      chk("R9 idle class under protect", cyc_state, 0);
      we_n = 1'b1;
      @(negedge clk); oe_n = 1'b0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (dout_en) drove = 1;
      end
      chk("R9 no drive under protect", drove, 0);
      cs_n = 1'b1; oe_n = 1'b1;
      @(negedge clk); wprot = 1'b0;
      idle(TR + SYNC + 4);
      do_read(30, 8'h33, "R9 write blocked");
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(3);
      t_read_timing();
      t_addr_switch();
      t_we_hiz();
      t_close_on_cs();
      t_open_late();
      t_proto();
      t_recovery();
      t_protect();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule